// File: doc/BRIEF.md
# Serial Programming ID-Write Sequencer

This block sits on the host side of a two-wire in-circuit serial programming link, with one clock line and one data line. Its job is to write the 8-byte identification area of a flash microcontroller. A single-cycle start pulse launches it. The four 16-bit ID words are captured at that moment from a small register file, so later changes on the word inputs have no effect on the run in progress.

The block then plays a fixed script of 14 frames. Each frame is a 4-bit command followed by a 16-bit payload, both shifted least-significant bit first:

- Three core-instruction frames enable code-memory writes.
- Six core-instruction frames point the target's table pointer at address 0x200000.
- Three table-write frames carry words 0 to 2, each advancing the address by two bytes.
- One table-write frame carries word 3 and starts programming.
- A final no-operation frame stretches its fourth clock: the clock stays high for the programming time, then low for the discharge time.

The block shows busy for the whole run. It pulses done for one cycle when the run finishes, and it leaves both lines driven low.

Top module: `idw_seq`

## Requirements
- R1: After reset, busy_o, done_o, ser_clk_o and ser_dat_o are all 0.
- R2: Every frame is 20 serial clocks: the 4 command bits, then the 16 payload bits, each field least-significant bit first. Data changes only when the clock rises and is stable until after it falls, when it is sampled. A run has exactly 14 frames (280 clocks).
- R3: Frames 0 to 2 use command 0000, with payloads 0x8EA6, 0x9CA6 and 0x84A6 in that order.
- R4: Frames 3 to 8 use command 0000, with payloads 0x0E20, 0x6EF8, 0x0E00, 0x6EF7, 0x0E00 and 0x6EF6 in that order.
- R5: Frames 9 to 11 use command 1101 (wire order 1,0,1,1). Their payloads are words 0, 1 and 2, where word k is id_words_i[16k+15:16k].
- R6: Frame 12 uses command 1111, and its payload is word 3.
- R7: Frame 13 has command 0000 and payload 0x0000. Its 4th clock is high for HOLD_HI_CYC cycles and then low for HOLD_LO_CYC cycles.
- R8: Every other clock phase lasts HALF_CYC cycles. busy_o is therefore high for 13*40*HALF_CYC + 38*HALF_CYC + HOLD_HI_CYC + HOLD_LO_CYC cycles.
- R9: A start pulse while busy_o is high is ignored. The ID words are captured only at the accepted start.
- R10: done_o is high for exactly one cycle, the first cycle with busy_o low after the last payload bit. Both serial lines are low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; acted on only when idle |
| id_words_i | input | 64 | Four ID words; word k occupies bits 16k+15:16k |
| ser_clk_o | output | 1 | Serial programming clock line |
| ser_dat_o | output | 1 | Serial programming data line (driven) |
| busy_o | output | 1 | High while the script is playing |
| done_o | output | 1 | One-cycle pulse at the end of the script |

## Verification
The situation hardest to reach from the ports is a start pulse arriving mid-run while the ID word inputs are also changing. A design that re-latches the words or restarts the script would still produce a correctly shaped frame stream, so neither fault shows up from the frame shape alone. The bench therefore raises start again several hundred cycles into a run, swaps the word inputs at the same moment, and decodes every clock of the run. It then confirms three things: the captured data frames still carry the first word set, the clock count is unchanged, and the busy duration is unchanged. The stretched hold clock is measured edge to edge in the same decode, so a wrong hold width or a misplaced hold also appears.

// File: rtl/idw_pkg.sv
package idw_pkg;
  localparam int CMD_BITS     = 4;
  localparam int PAY_BITS     = 16;
  localparam int FRAME_BITS   = CMD_BITS + PAY_BITS;
  localparam int NUM_WORDS    = 4;
  localparam int WORDS_W      = NUM_WORDS * PAY_BITS;
  localparam int CORE_FRAMES  = 9;
  localparam int PROG_FRAME   = CORE_FRAMES + NUM_WORDS - 1;
  localparam int NUM_FRAMES   = PROG_FRAME + 2;
  localparam int HOLD_BIT     = 3;
  localparam int FIDX_W       = $clog2(NUM_FRAMES);
  localparam int BIDX_W       = $clog2(FRAME_BITS);

  localparam logic [CMD_BITS-1:0] CMD_CORE    = 4'h0;
  localparam logic [CMD_BITS-1:0] CMD_WR_INC  = 4'hD;
  localparam logic [CMD_BITS-1:0] CMD_WR_PROG = 4'hF;

  function automatic logic [CMD_BITS-1:0] frame_cmd(logic [FIDX_W-1:0] f);
    if (f < FIDX_W'(CORE_FRAMES)) return CMD_CORE;
    else if (f < FIDX_W'(PROG_FRAME)) return CMD_WR_INC;
    else if (f == FIDX_W'(PROG_FRAME)) return CMD_WR_PROG;
    else return CMD_CORE;
  endfunction

  function automatic logic [PAY_BITS-1:0] core_payload(logic [FIDX_W-1:0] f);
    case (f)
      4'd0: return 16'h8EA6;
      4'd1: return 16'h9CA6;
      4'd2: return 16'h84A6;
      4'd3: return 16'h0E20;
      4'd4: return 16'h6EF8;
      4'd5: return 16'h0E00;
      4'd6: return 16'h6EF7;
      4'd7: return 16'h0E00;
      4'd8: return 16'h6EF6;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int phase_len(logic hold, logic hi, int half, int phi, int plo);
    if (!hold) return half;
    return hi ? phi : plo;
  endfunction
endpackage

// File: rtl/idw_phase_timer.sv
module idw_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == len_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || last_o) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BELOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_i)); // R8
endmodule

// File: rtl/idw_bit_sel.sv
module idw_bit_sel
  import idw_pkg::*;
(
  input  logic [FIDX_W-1:0]  frame_i,
  input  logic [BIDX_W-1:0]  bit_i,
  input  logic [WORDS_W-1:0] words_i,
  output logic               bit_o
);
  logic                  is_data;
  logic [1:0]            wsel;
  logic [PAY_BITS-1:0]   payload;
  logic [FRAME_BITS-1:0] frame_vec;

  assign is_data   = (frame_i >= FIDX_W'(CORE_FRAMES)) && (frame_i <= FIDX_W'(PROG_FRAME));
  assign wsel      = 2'(frame_i - FIDX_W'(CORE_FRAMES));
  assign payload   = is_data ? words_i[{wsel, 4'b0000} +: PAY_BITS] : core_payload(frame_i);
  assign frame_vec = {payload, frame_cmd(frame_i)};
  assign bit_o     = frame_vec[bit_i];
endmodule

// File: rtl/idw_seq.sv
module idw_seq
  import idw_pkg::*;
#(
  parameter int HALF_CYC    = 2,
  parameter int HOLD_HI_CYC = 20,
  parameter int HOLD_LO_CYC = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WORDS_W-1:0] id_words_i,
  output logic               ser_clk_o,
  output logic               ser_dat_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int MAXLEN = (HOLD_HI_CYC > HOLD_LO_CYC) ?
    ((HOLD_HI_CYC > HALF_CYC) ? HOLD_HI_CYC : HALF_CYC) :
    ((HOLD_LO_CYC > HALF_CYC) ? HOLD_LO_CYC : HALF_CYC);
  localparam int CW = $clog2(MAXLEN + 1);
  localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(NUM_FRAMES - 1);
  localparam logic [BIDX_W-1:0] LAST_BIT   = BIDX_W'(FRAME_BITS - 1);

  logic               busy_q, phase_hi_q, done_q;
  logic [FIDX_W-1:0]  frame_q;
  logic [BIDX_W-1:0]  bit_q;
  logic [WORDS_W-1:0] words_q;

  // named events
  logic          start_acc, hold_bit, phase_end, frame_end, seq_end, cur_bit;
  logic [CW-1:0] cur_len;

  assign start_acc = start_i && !busy_q;
  assign hold_bit  = busy_q && (frame_q == LAST_FRAME) && (bit_q == BIDX_W'(HOLD_BIT));
  assign cur_len   = CW'(phase_len(hold_bit, phase_hi_q, HALF_CYC, HOLD_HI_CYC, HOLD_LO_CYC));
  assign frame_end = phase_end && !phase_hi_q && (bit_q == LAST_BIT);
  assign seq_end   = frame_end && (frame_q == LAST_FRAME);

  idw_phase_timer #(.CW(CW)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q), .len_i(cur_len), .last_o(phase_end)
  );

  idw_bit_sel bitsel_i (
    .frame_i(frame_q), .bit_i(bit_q), .words_i(words_q), .bit_o(cur_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      phase_hi_q <= 1'b0;
      done_q     <= 1'b0;
      frame_q    <= '0;
      bit_q      <= '0;
      words_q    <= '0;
    end else begin
      done_q <= seq_end;
      if (start_acc) begin
        busy_q     <= 1'b1;
        phase_hi_q <= 1'b1;
        frame_q    <= '0;
        bit_q      <= '0;
        words_q    <= id_words_i;
      end else if (phase_end) begin
        if (phase_hi_q) begin
          phase_hi_q <= 1'b0;
        end else if (seq_end) begin
          busy_q  <= 1'b0;
          frame_q <= '0;
          bit_q   <= '0;
        end else begin
          phase_hi_q <= 1'b1;
          if (frame_end) begin
            bit_q   <= '0;
            frame_q <= frame_q + FIDX_W'(1);
          end else begin
            bit_q <= bit_q + BIDX_W'(1);
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ser_clk_o = busy_q && phase_hi_q;
  assign ser_dat_o = busy_q && cur_bit;

  AST_IDLE_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ser_clk_o && !ser_dat_o)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R10
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_dat_o)); // R2
  AST_DATA_STABLE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $fell(ser_clk_o)) |-> $stable(ser_dat_o)); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !phase_end) |=> ($stable(frame_q) && $stable(bit_q) && $stable(words_q))); // R9
  AST_INDEX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_q <= LAST_FRAME) && (bit_q <= LAST_BIT)); // R2
endmodule

// File: tb/idw_seq_tb.sv
module idw_seq_tb_top;
  localparam int HALF = 2;
  localparam int P9   = 23;
  localparam int P10  = 11;
  localparam int NCLK = 280;
  localparam int HOLD_IDX = 13 * 20 + 3;
  localparam int EXP_BUSY = 13 * 40 * HALF + 38 * HALF + P9 + P10;

  localparam logic [15:0] CORE_TBL [9] = '{16'h8EA6, 16'h9CA6, 16'h84A6,
    16'h0E20, 16'h6EF8, 16'h0E00, 16'h6EF7, 16'h0E00, 16'h6EF6};
  localparam logic [63:0] VEC [4] = '{64'h1234_5678_9ABC_DEF0, 64'h0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_5A5A_0F0F_F0F0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] words = '0;
  logic sclk, sdat, busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  idw_seq #(.HALF_CYC(HALF), .HOLD_HI_CYC(P9), .HOLD_LO_CYC(P10)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .id_words_i(words),
    .ser_clk_o(sclk), .ser_dat_o(sdat), .busy_o(busy), .done_o(done));

  // wire monitor
  logic cap_bits [NCLK];
  int   hi_w [NCLK];
  int   lo_w [NCLK];
  int   m_n = 0, m_hi = 0, m_lo = 0, m_busy_cyc = 0, m_done_cnt = 0;
  bit   m_done_ok = 0, m_pclk = 0, m_pbusy = 0;

  always @(negedge clk) begin
    if (busy && !m_pbusy) begin
      m_n = 0; m_hi = 0; m_lo = 0; m_busy_cyc = 0; m_done_cnt = 0; m_done_ok = 0;
    end
    if (busy) begin
      m_busy_cyc++;
      if (sclk && !m_pclk) begin
        if (m_n > 0 && m_n <= NCLK) lo_w[m_n-1] = m_lo;
        m_hi = 1;
      end else if (sclk) m_hi++;
      else if (m_pclk) begin
        if (m_n < NCLK) begin hi_w[m_n] = m_hi; cap_bits[m_n] = sdat; end
        m_n++; m_lo = 1;
      end else m_lo++;
    end else if (m_pbusy && m_n > 0 && m_n <= NCLK) lo_w[m_n-1] = m_lo;
    if (done) begin
      m_done_cnt++;
      if (m_pbusy && !busy && !sclk && !sdat) m_done_ok = 1;
    end
    m_pclk = sclk; m_pbusy = busy;
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] cap_frame(int f);
    logic [19:0] v;
    for (int i = 0; i < 20; i++) v[i] = cap_bits[f*20 + i];
    return v;
  endfunction

  function automatic logic [19:0] exp_frame(int f, logic [63:0] w);
    if (f < 9) return {CORE_TBL[f], 4'b0000};
    if (f < 12) return {w[(f-9)*16 +: 16], 4'b1101};
    if (f == 12) return {w[63:48], 4'b1111};
    return 20'h0;
  endfunction

  task automatic pulse_start(logic [63:0] w);
    @(posedge clk); #1;
    words = w; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_end();
    int k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_run(logic [63:0] w, string tag);
    int bad = 0;
    chk(m_n == NCLK, {"R2 clock count ", tag}, m_n, NCLK);
    for (int f = 0; f < 14; f++) begin
      logic [19:0] a = cap_frame(f);
      logic [19:0] e = exp_frame(f, w);
      string r = (f < 3) ? "R3" : (f < 9) ? "R4" : (f < 12) ? "R5" : (f == 12) ? "R6" : "R7";
      chk(a == e, $sformatf("%s frame %0d %s", r, f, tag), a, e);
    end
    chk(hi_w[HOLD_IDX] == P9, {"R7 hold high ", tag}, hi_w[HOLD_IDX], P9);
    chk(lo_w[HOLD_IDX] == P10, {"R7 hold low ", tag}, lo_w[HOLD_IDX], P10);
    for (int i = 0; i < NCLK; i++)
      if (i != HOLD_IDX && (hi_w[i] != HALF || lo_w[i] != HALF)) bad++;
    chk(bad == 0, {"R8 normal phase widths ", tag}, bad, 0);
    chk(m_busy_cyc == EXP_BUSY, {"R8 busy length ", tag}, m_busy_cyc, EXP_BUSY);
    chk(m_done_cnt == 1, {"R10 done pulse count ", tag}, m_done_cnt, 1);
    chk(m_done_ok, {"R10 done at busy fall, lines low ", tag}, m_done_ok, 1);
    chk(!busy && !sclk && !sdat, {"R10 idle after run ", tag}, {busy, sclk, sdat}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sclk && !sdat, "R1 reset outputs", {busy, done, sclk, sdat}, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !sclk && !sdat, "R1 idle after reset", {busy, done, sclk, sdat}, 0);

    // vector table walk
    for (int v = 0; v < 4; v++) begin
      pulse_start(VEC[v]);
      words = ~VEC[v];
      wait_end();
      check_run(VEC[v], $sformatf("vec%0d", v));
    end

    // R9: start while busy, with changed words
    pulse_start(VEC[0]);
    repeat (300) @(posedge clk);
    pulse_start(VEC[3]);
    repeat (100) @(posedge clk);
    #1 start = 1'b1;
    repeat (5) @(posedge clk);
    #1 start = 1'b0;
    wait_end();
    check_run(VEC[0], "R9 restart ignored");
    chk(m_n == NCLK && m_busy_cyc == EXP_BUSY, "R9 run length unchanged", m_busy_cyc, EXP_BUSY);

    // R9: a fresh start after idle takes the new words
    pulse_start(VEC[2]);
    wait_end();
    chk(cap_frame(9) == {VEC[2][15:0], 4'b1101}, "R9 new words on next start",
        cap_frame(9), {VEC[2][15:0], 4'b1101});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule